// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block shifts or rotates one operand word for a data-processing or address-offset datapath and produces the shifter carry that a later flag update may use. The operand, a three-bit shift kind, a shift amount and the current carry flag arrive together. The shifted word and the carry-out are ready in the same cycle.

Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and an extended rotate. The extended rotate moves the word right by one place and shifts the incoming carry into the top bit. Each kind accepts only its own range of amounts. A right shift may move all 32 places, while a left shift or a plain rotate stops one short of the width. If the amount is outside the range for the selected kind, or the kind code is unused, the block raises an error flag and passes the operand and the carry through unchanged.

The datapath has no clock, no storage and no handshake. The instruction decode that selects the kind and the amount sits upstream of it. The ALU that uses the result sits downstream.

Top module: `opnd_shifter`

## Requirements
- R1: The kind code selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right and 4 is extended rotate. Codes 5, 6 and 7 are unused and always raise `range_err_o`.
- R2: Logical left accepts amounts 0 to 31. For an amount n of 1 or more, the result is the operand shifted left n places with zeros entering at bit 0, and the carry-out is operand bit 32-n.
- R3: Logical left by 0 returns the operand unchanged, and the carry-out equals `carry_i`.
- R4: Logical right accepts amounts 1 to 32. Zeros enter at the top, and the carry-out is operand bit n-1. An amount of 32 gives zero, with the carry-out equal to operand bit 31.
- R5: Arithmetic right accepts amounts 1 to 32. Copies of operand bit 31 enter at the top, and the carry-out is operand bit n-1. An amount of 32 gives 32 copies of bit 31, with the carry-out equal to bit 31.
- R6: Rotate right accepts amounts 1 to 31. Bits leaving bit 0 re-enter at bit 31, and the carry-out is operand bit n-1.
- R7: Extended rotate ignores the amount. The result is `carry_i` in bit 31 with operand bits 31..1 in bits 30..0, and the carry-out is operand bit 0.
- R8: An amount outside the legal range of the selected kind drives `range_err_o` high, `result_o` equal to the operand and `carry_o` equal to `carry_i`. For every legal combination, `range_err_o` is low.
- R9: All outputs are combinational functions of the present inputs and are valid in the same cycle that the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to shift or rotate |
| kind_i | input | 3 | Shift kind code (see R1) |
| amt_i | input | 6 | Shift amount, 0 to 63 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |
| range_err_o | output | 1 | Amount or kind out of range |

## Verification
The block has no registers, so every result and the error flag are due in the same cycle as the stimulus. The bench applies each input combination on a falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. It sweeps all eight kind codes against every amount from 0 to 63, for several operand patterns and both carry values. Each sample is compared with a value the bench computes using wide arithmetic.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;
  typedef enum logic [2:0] {
    KIND_SLL  = 3'd0,
    KIND_SRL  = 3'd1,
    KIND_SRA  = 3'd2,
    KIND_ROTR = 3'd3,
    KIND_XROT = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/opnd_range_chk.sv
module opnd_range_chk
  import opnd_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  output logic          legal
);
  localparam logic [AW-1:0] FULL = AW'(W);
  localparam logic [AW-1:0] LAST = AW'(W - 1);

  always_comb begin
    unique case (kind)
      KIND_SLL:          legal = (amt <= LAST);
      KIND_SRL, KIND_SRA: legal = (amt != '0) && (amt <= FULL);
      KIND_ROTR:         legal = (amt != '0) && (amt <= LAST);
      KIND_XROT:         legal = 1'b1;
      default:           legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          fill,
  input  logic          rotate,
  input  logic          mirror,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:AW];
  logic [W-1:0] din_rev;
  logic [W-1:0] last_rev;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_rev
      assign din_rev[b]  = din[W-1-b];
      assign last_rev[b] = stage[AW][W-1-b];
    end
  endgenerate

  assign stage[0] = mirror ? din_rev : din;

  genvar k;
  generate
    for (k = 0; k < AW; k++) begin : g_stage
      localparam int SH = 1 << k;
      logic [W-1:0] moved;
      if (SH < W) begin : g_part
        assign moved = rotate ? {stage[k][SH-1:0], stage[k][W-1:SH]}
                              : {{SH{fill}}, stage[k][W-1:SH]};
      end else begin : g_full
        assign moved = {W{fill}};
      end
      assign stage[k+1] = amt[k] ? moved : stage[k];
    end
  endgenerate

  assign dout = mirror ? last_rev : stage[AW];
endmodule

// File: rtl/opnd_carry_pick.sv
module opnd_carry_pick
  import opnd_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          carry_in,
  output logic          carry_out
);
  logic [AW-1:0] idx;

  always_comb begin
    if (kind == KIND_SLL) idx = AW'(W) - amt;
    else                  idx = amt - AW'(1);
  end

  always_comb begin
    carry_out = carry_in;
    if (kind == KIND_XROT) begin
      carry_out = din[0];
    end else if (amt != '0) begin
      for (int i = 0; i < W; i++) begin
        if (idx == AW'(i)) carry_out = din[i];
      end
    end
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  opnd_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o,
  output logic          range_err_o
);
  logic         legal;
  logic [W-1:0] core_out;
  logic         pick_carry;
  logic         fill_bit;
  logic         is_rot;
  logic         is_left;

  assign fill_bit = (kind_i == KIND_SRA) ? opnd_i[W-1] : 1'b0;
  assign is_rot   = (kind_i == KIND_ROTR);
  assign is_left  = (kind_i == KIND_SLL);

  opnd_range_chk #(.W(W), .AW(AW)) u_range (
    .kind  (kind_i),
    .amt   (amt_i),
    .legal (legal)
  );

  opnd_shift_core #(.W(W), .AW(AW)) u_core (
    .din    (opnd_i),
    .amt    (amt_i),
    .fill   (fill_bit),
    .rotate (is_rot),
    .mirror (is_left),
    .dout   (core_out)
  );

  opnd_carry_pick #(.W(W), .AW(AW)) u_carry (
    .din       (opnd_i),
    .kind      (kind_i),
    .amt       (amt_i),
    .carry_in  (carry_i),
    .carry_out (pick_carry)
  );

  always_comb begin
    range_err_o = ~legal;
    if (!legal) begin
      result_o = opnd_i;
      carry_o  = carry_i;
    end else if (kind_i == KIND_XROT) begin
      result_o = {carry_i, opnd_i[W-1:1]};
      carry_o  = pick_carry;
    end else begin
      result_o = core_out;
      carry_o  = pick_carry;
    end
  end

  always_comb begin
    // R8
    pass_on_err_chk: assert (!range_err_o || (result_o == opnd_i && carry_o == carry_i))
      else $error("error path altered operand or carry");
    // R3
    sll_zero_chk: assert (!(kind_i == KIND_SLL && amt_i == '0) || (result_o == opnd_i && carry_o == carry_i))
      else $error("left shift by zero not transparent");
    // R7
    xrot_chk: assert (kind_i != KIND_XROT || (result_o[W-1] == carry_i && carry_o == opnd_i[0]))
      else $error("extended rotate wrong");
    // R6
    rotr_pop_chk: assert (range_err_o || kind_i != KIND_ROTR || $countones(result_o) == $countones(opnd_i))
      else $error("rotate lost bits");
    // R5
    sra_sign_chk: assert (range_err_o || kind_i != KIND_SRA || result_o[W-1] == opnd_i[W-1])
      else $error("arithmetic shift lost sign");
    // R4
    srl_top_chk: assert (range_err_o || kind_i != KIND_SRL || result_o[W-1] == 1'b0)
      else $error("logical right shift top bit set");
  end
endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;
  localparam int W = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]  opnd = '0;
  logic [2:0]    kind = '0;
  logic [AW-1:0] amt = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  res;
  logic          cout;
  logic          err;

  int checks = 0;
  int fails = 0;

  opnd_shifter u_dut (
    .opnd_i(opnd), .kind_i(kind), .amt_i(amt), .carry_i(cin),
    .result_o(res), .carry_o(cout), .range_err_o(err)
  );

  function automatic string tag_of(input int k, input int n, input bit bad);
    if (bad) return (k > 4) ? "R1" : "R8";
    case (k)
      0: return (n == 0) ? "R3" : "R2";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_one(input logic [W-1:0] x, input int k, input int n, input bit c);
    logic [W-1:0] e_res;
    logic e_c, e_err;
    logic [63:0] wide;
    @(negedge clk);
    opnd = x; kind = 3'(k); amt = AW'(n); cin = c;
    e_err = 1'b0; e_res = x; e_c = c;
    case (k)
      0: if (n <= 31) begin
           wide = {32'b0, x} << n; e_res = wide[31:0];
           if (n > 0) e_c = wide[32];
         end else e_err = 1'b1;
      1: if (n >= 1 && n <= 32) begin
           wide = {x, 32'b0} >> n; e_res = wide[63:32]; e_c = wide[31];
         end else e_err = 1'b1;
      2: if (n >= 1 && n <= 32) begin
           wide = {{32{x[31]}}, x} >> n; e_res = wide[31:0]; e_c = x[n-1];
           for (int i = 32 - n; i < 32; i++) e_res[i] = x[31];
         end else e_err = 1'b1;
      3: if (n >= 1 && n <= 31) begin
           wide = {x, x} >> n; e_res = wide[31:0]; e_c = x[n-1];
         end else e_err = 1'b1;
      4: begin e_res = {c, x[31:1]}; e_c = x[0]; end
      default: e_err = 1'b1;
    endcase
    #1;
    checks++;
    if (res !== e_res || cout !== e_c || err !== e_err) begin
      fails++;
      $display("FAIL %s kind=%0d amt=%0d opnd=%h cin=%0b: got res=%h c=%0b err=%0b exp res=%h c=%0b err=%0b (R9 same-cycle)",
               tag_of(k, n, e_err), k, n, x, c, res, cout, err, e_res, e_c, e_err);
    end
  endtask

  initial begin
    logic [W-1:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0001; pats[3] = 32'h7FFF_FFFE;
    pats[4] = 32'hA5C3_0F96; pats[5] = 32'h1234_5678;
    pats[6] = 32'hDEAD_BEEF; pats[7] = 32'h0000_0001;
    // reset state: all-zero inputs give zero result, no error (R3)
    #1;
    checks++;
    if (res !== '0 || cout !== 1'b0 || err !== 1'b0) begin
      fails++;
      $display("FAIL R3 idle: got res=%h c=%0b err=%0b exp 0/0/0", res, cout, err);
    end
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 64; n++)
          for (int c = 0; c < 2; c++)
            check_one(pats[p], k, n, c[0]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired: got running exp done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule